// File: doc/BRIEF.md
# Dirty Scanline Run Coalescer

This block turns a per-line "changed" flag stream into a short list of screen update rectangles. After a start pulse it takes one flag per scanline, top line first, over a valid/ready handshake, and folds every stretch of consecutive changed lines into one record holding the first line of the stretch and how many lines it covers. Every record spans the whole mode width from column 0, so the width captured at start is repeated on each record.

When the caller asks for a full repaint, typically because the video mode just changed, the per-line scan is skipped and a single record covering the whole screen is produced. Records leave over their own valid/ready handshake. The line scan waits whenever a record cannot be handed on. A one-cycle done pulse closes each frame once the last record has been taken.

Top module: `scanrun_coalescer`

## Requirements
- R1: After reset the block is idle: `rec_valid_o`, `done_o` and `dirty_ready_o` are all low.
- R2: While no stretch is open, a changed line (flag 1) opens one, and that line's index becomes the record's first line `rec_y_o`.
- R3: The first unchanged line (flag 0) after an open stretch closes it, and the record count `rec_n_o` equals that line's index minus the first line.
- R4: A stretch still open after line height−1 is emitted with count equal to height minus its first line.
- R5: Every record carries `rec_x_o` = 0 and `rec_w_o` equal to `width_i` as sampled with the accepted start pulse.
- R6: With `full_i` = 1 at start, exactly one record (first line 0, count = height) is emitted, and `dirty_ready_o` stays low for the whole frame.
- R7: A frame whose flags are all 0 emits no record and only pulses `done_o`.
- R8: A record whose handshake has not completed keeps `rec_valid_o` high and its fields unchanged. While such a record waits, `dirty_ready_o` is low, and no record is lost when the consumer stalls.
- R9: A start pulse that arrives before the running frame's done pulse is ignored, together with its height, width and full-repaint inputs.
- R10: `done_o` is high for exactly one cycle per frame, and only after every record of that frame has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start pulse, honoured only while idle |
| full_i | input | 1 | Request one whole-screen record instead of a scan |
| height_i | input | LINE_W | Number of scanlines in the frame |
| width_i | input | COL_W | Mode width in pixels |
| dirty_valid_i | input | 1 | Line flag is present |
| dirty_bit_i | input | 1 | 1 = the current line changed |
| dirty_ready_o | output | 1 | Block accepts the line flag this cycle |
| rec_valid_o | output | 1 | A record is presented |
| rec_ready_i | input | 1 | Consumer takes the record this cycle |
| rec_x_o | output | COL_W | Record first column (always 0) |
| rec_y_o | output | LINE_W | Record first line |
| rec_w_o | output | COL_W | Record width in pixels |
| rec_n_o | output | LINE_W | Record line count |
| done_o | output | 1 | Frame finished, one cycle |

## Verification
The two functions that can meet in one cycle are the hand-off of a pending record to the consumer and the loading of the next record produced by a closing stretch. Alternating flag patterns such as 1010 close a stretch every other line, so that collision happens often. The bench makes it likely by driving `rec_ready_i` from rotating 8-bit masks, so acceptance, stall and refill land in many different cycles. It then requires that the collected record list match the list computed from the flags exactly, with nothing lost and nothing duplicated. It also requires that a stalled record stay frozen and that the flag input be refused while the record waits.

// File: rtl/scanrun_pkg.sv
package scanrun_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_FULL = 2'd2,
      ST_FIN  = 2'd3
   } scan_state_t;

   function automatic bit width_ok(input int lw, input int cw);
      return (lw >= 2) && (lw <= 16) && (cw >= 1) && (cw <= 16);
   endfunction
endpackage

// File: rtl/scanrun_ctrl.sv
module scanrun_ctrl
   import scanrun_pkg::*;
#(
   parameter int LINE_W = 12,
   parameter int COL_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              full_i,
   input  logic [LINE_W-1:0] height_i,
   input  logic [COL_W-1:0]  width_i,
   input  logic              dirty_valid_i,
   input  logic              can_push_i,
   input  logic              out_empty_i,
   output logic              dirty_ready_o,
   output logic              accept_o,
   output logic              clear_o,
   output logic              last_o,
   output logic [LINE_W-1:0] line_o,
   output logic [LINE_W-1:0] height_o,
   output logic [COL_W-1:0]  width_o,
   output logic              full_push_o,
   output logic              done_o
);
   scan_state_t       state_q, state_d;
   logic [LINE_W-1:0] line_q, height_q;
   logic [COL_W-1:0]  width_q;
   logic              full_q;
   logic              take_start;

   assign take_start    = (state_q == ST_IDLE) && start_i;
   assign dirty_ready_o = (state_q == ST_SCAN) && can_push_i;
   assign accept_o      = dirty_ready_o && dirty_valid_i;
   assign last_o        = (line_q == height_q - 1'b1);
   assign full_push_o   = (state_q == ST_FULL) && can_push_i;
   assign done_o        = (state_q == ST_FIN) && out_empty_i;
   assign clear_o       = take_start;
   assign line_o        = line_q;
   assign height_o      = height_q;
   assign width_o       = width_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            if (full_i)                state_d = ST_FULL;
            else if (height_i == '0)   state_d = ST_FIN;
            else                       state_d = ST_SCAN;
         end
         ST_SCAN: if (accept_o && last_o) state_d = ST_FIN;
         ST_FULL: if (full_push_o)        state_d = ST_FIN;
         ST_FIN:  if (out_empty_i)        state_d = ST_IDLE;
         default:                         state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         line_q   <= '0;
         height_q <= '0;
         width_q  <= '0;
         full_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (take_start) begin
            line_q   <= '0;
            height_q <= height_i;
            width_q  <= width_i;
            full_q   <= full_i;
         end else if (accept_o && !last_o) begin
            line_q <= line_q + 1'b1;
         end
      end
   end

   // R6: a full-repaint frame never asks for line flags
   a_r6_full_no_scan: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && state_q != ST_IDLE) |-> !dirty_ready_o);
   // R10: done is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R9: a busy frame keeps its captured height
   a_r9_height_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(height_q));
endmodule

// File: rtl/scanrun_tracker.sv
module scanrun_tracker #(
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              accept_i,
   input  logic              bit_i,
   input  logic              last_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic [LINE_W-1:0] height_i,
   output logic              push_o,
   output logic [LINE_W-1:0] push_y_o,
   output logic [LINE_W-1:0] push_n_o
);
   logic              open_q;
   logic [LINE_W-1:0] first_q;
   logic [LINE_W-1:0] first_eff;
   logic              closing, flushing;

   assign first_eff = open_q ? first_q : line_i;
   assign closing   = accept_i && !bit_i && open_q;
   assign flushing  = accept_i && bit_i && last_i;
   assign push_o    = closing || flushing;
   assign push_y_o  = first_eff;
   assign push_n_o  = flushing ? (height_i - first_eff) : (line_i - first_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         first_q <= '0;
      end else if (clear_i) begin
         open_q  <= 1'b0;
         first_q <= '0;
      end else if (accept_i) begin
         if (last_i)                begin open_q <= 1'b0; end
         else if (bit_i && !open_q) begin open_q <= 1'b1; first_q <= line_i; end
         else if (!bit_i)           begin open_q <= 1'b0; end
      end
   end

   // R2: an open stretch never starts beyond the current line
   a_r2_first_behind: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !clear_i) |-> (first_q <= line_i));
   // R3: a pushed count is never zero
   a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> (push_n_o != '0));
endmodule

// File: rtl/scanrun_outbuf.sv
module scanrun_outbuf #(
   parameter int LINE_W = 12,
   parameter int COL_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [LINE_W-1:0] y_i,
   input  logic [LINE_W-1:0] n_i,
   input  logic [COL_W-1:0]  w_i,
   input  logic              ready_i,
   output logic              can_push_o,
   output logic              valid_o,
   output logic [LINE_W-1:0] y_o,
   output logic [LINE_W-1:0] n_o,
   output logic [COL_W-1:0]  w_o,
   output logic [COL_W-1:0]  x_o
);
   assign can_push_o = !valid_o || ready_i;
   assign x_o        = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         y_o     <= '0;
         n_o     <= '0;
         w_o     <= '0;
      end else if (push_i && can_push_o) begin
         valid_o <= 1'b1;
         y_o     <= y_i;
         n_o     <= n_i;
         w_o     <= w_i;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end

   // R8: a waiting record stays presented and frozen
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(y_o) && $stable(n_o) && $stable(w_o)));
   // R8: nothing is pushed into an occupied buffer
   a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> can_push_o);
endmodule

// File: rtl/scanrun_coalescer.sv
module scanrun_coalescer
   import scanrun_pkg::*;
#(
   parameter int LINE_W = 12,
   parameter int COL_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              full_i,
   input  logic [LINE_W-1:0] height_i,
   input  logic [COL_W-1:0]  width_i,
   input  logic              dirty_valid_i,
   input  logic              dirty_bit_i,
   output logic              dirty_ready_o,
   output logic              rec_valid_o,
   input  logic              rec_ready_i,
   output logic [COL_W-1:0]  rec_x_o,
   output logic [LINE_W-1:0] rec_y_o,
   output logic [COL_W-1:0]  rec_w_o,
   output logic [LINE_W-1:0] rec_n_o,
   output logic              done_o
);
   localparam int SUM_W = LINE_W + 1;

   generate
      if (!width_ok(LINE_W, COL_W)) begin : g_bad_widths
         $error("scanrun_coalescer: LINE_W must be 2..16 and COL_W 1..16");
      end
   endgenerate

   logic              can_push, accept, clear, last, full_push;
   logic [LINE_W-1:0] line, height_q;
   logic [COL_W-1:0]  width_q;
   logic              trk_push;
   logic [LINE_W-1:0] trk_y, trk_n;
   logic              push;
   logic [LINE_W-1:0] push_y, push_n;

   scanrun_ctrl #(.LINE_W(LINE_W), .COL_W(COL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .full_i(full_i),
      .height_i(height_i), .width_i(width_i), .dirty_valid_i(dirty_valid_i),
      .can_push_i(can_push), .out_empty_i(!rec_valid_o),
      .dirty_ready_o(dirty_ready_o), .accept_o(accept), .clear_o(clear),
      .last_o(last), .line_o(line), .height_o(height_q), .width_o(width_q),
      .full_push_o(full_push), .done_o(done_o)
   );

   scanrun_tracker #(.LINE_W(LINE_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .accept_i(accept),
      .bit_i(dirty_bit_i), .last_i(last), .line_i(line), .height_i(height_q),
      .push_o(trk_push), .push_y_o(trk_y), .push_n_o(trk_n)
   );

   assign push   = trk_push || full_push;
   assign push_y = full_push ? '0 : trk_y;
   assign push_n = full_push ? height_q : trk_n;

   scanrun_outbuf #(.LINE_W(LINE_W), .COL_W(COL_W)) u_out (
      .clk(clk), .rst_n(rst_n), .push_i(push), .y_i(push_y), .n_i(push_n),
      .w_i(width_q), .ready_i(rec_ready_i), .can_push_o(can_push),
      .valid_o(rec_valid_o), .y_o(rec_y_o), .n_o(rec_n_o), .w_o(rec_w_o),
      .x_o(rec_x_o)
   );

   // R4: every record fits inside the frame height
   a_r4_fits: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> ({1'b0, rec_y_o} + {1'b0, rec_n_o} <= SUM_W'(height_q)));
   // R8: the line scan waits while a record is refused
   a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_o && !rec_ready_i) |-> !dirty_ready_o);
   // R10: done only once the record buffer is empty
   a_r10_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !rec_valid_o);
   // R5: records start at column 0
   a_r5_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> (rec_x_o == '0));
endmodule

// File: tb/scanrun_coalescer_bench.sv
module scanrun_coalescer_bench;
   localparam int LW = 12;
   localparam int CW = 12;

   typedef struct packed {
      logic [6:0]  h;
      logic        full;
      logic [63:0] bits;
      logic [7:0]  rpat;
      logic [11:0] w;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{7'd8,  1'b0, 64'h3C,                  8'hFF, 12'd640},
      '{7'd8,  1'b0, 64'hFF,                  8'hB7, 12'd800},
      '{7'd8,  1'b0, 64'h0,                   8'hFF, 12'd320},
      '{7'd16, 1'b0, 64'hA5A5,                8'h55, 12'd1024},
      '{7'd10, 1'b0, 64'h201,                 8'h33, 12'd100},
      '{7'd12, 1'b1, 64'hFFFF,                8'h0F, 12'd720},
      '{7'd1,  1'b0, 64'h1,                   8'hFF, 12'd64},
      '{7'd64, 1'b0, 64'hF0F0_0000_FFFF_0001, 8'hB6, 12'd1280}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, full_i = 1'b0;
   logic [LW-1:0] height_i = '0;
   logic [CW-1:0] width_i = '0;
   logic dirty_valid_i = 1'b0, dirty_bit_i = 1'b0, rec_ready_i = 1'b0;
   logic dirty_ready_o, rec_valid_o, done_o;
   logic [CW-1:0] rec_x_o, rec_w_o;
   logic [LW-1:0] rec_y_o, rec_n_o;

   int n_chk = 0, n_err = 0;
   int got_y [80];
   int got_n [80];
   int exp_y [80];
   int exp_n [80];

   always #2.5 clk = ~clk;

   scanrun_coalescer #(.LINE_W(LW), .COL_W(CW)) u_scanrun_coalescer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .full_i(full_i),
      .height_i(height_i), .width_i(width_i), .dirty_valid_i(dirty_valid_i),
      .dirty_bit_i(dirty_bit_i), .dirty_ready_o(dirty_ready_o),
      .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
      .rec_x_o(rec_x_o), .rec_y_o(rec_y_o), .rec_w_o(rec_w_o),
      .rec_n_o(rec_n_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected records from the requirements R2, R3, R4, R6, R7
   function automatic int expect_list(input int h, input bit full, input logic [63:0] b);
      int ne = 0;
      bit open = 0;
      int s = 0;
      if (full) begin
         exp_y[0] = 0; exp_n[0] = h; return 1;
      end
      for (int l = 0; l < h; l++) begin
         if (b[l] && !open) begin open = 1; s = l; end
         else if (!b[l] && open) begin exp_y[ne] = s; exp_n[ne] = l - s; ne++; open = 0; end
      end
      if (open) begin exp_y[ne] = s; exp_n[ne] = h - s; ne++; end
      return ne;
   endfunction

   task automatic run_frame(input int h, input bit full, input logic [63:0] b,
                            input logic [7:0] rpat, input int w, input int restart_cyc,
                            input string tag);
      int n = 0, idx = 0, cyc = 0, ne, ndone = 0;
      bit fin = 0, w_ok = 1, x_ok = 1, stall_ok = 1, scan_seen = 0, hold_ok = 1;
      bit prev_wait = 0;
      int prev_y = 0, prev_n = 0;
      ne = expect_list(h, full, b);
      @(posedge clk); #1;
      start_i = 1; height_i = LW'(h); width_i = CW'(w); full_i = full;
      @(posedge clk); #1;
      start_i = 0;
      while (!fin && cyc < 3000) begin
         if (cyc == restart_cyc) begin
            start_i = 1; full_i = 1; height_i = 5; width_i = 7;
         end else begin
            start_i = 0;
         end
         rec_ready_i   = rpat[cyc % 8];
         dirty_valid_i = !full && (idx < h);
         dirty_bit_i   = (idx < 64) ? b[idx] : 1'b0;
         @(negedge clk);
         if (prev_wait && !(rec_valid_o && rec_y_o == LW'(prev_y) && rec_n_o == LW'(prev_n)))
            hold_ok = 0;
         prev_wait = rec_valid_o && !rec_ready_i;
         prev_y = rec_y_o; prev_n = rec_n_o;
         if (rec_valid_o && !rec_ready_i && dirty_ready_o) stall_ok = 0;
         if (dirty_ready_o) scan_seen = 1;
         if (rec_valid_o && rec_ready_i) begin
            if (n < 80) begin got_y[n] = rec_y_o; got_n[n] = rec_n_o; end
            if (rec_w_o != CW'(w)) w_ok = 0;
            if (rec_x_o != '0) x_ok = 0;
            n++;
         end
         if (dirty_valid_i && dirty_ready_o) idx++;
         if (done_o) begin
            ndone++;
            check(n == ne, {tag, " R10 all records before done"}, n, ne);
            fin = 1;
         end
         @(posedge clk); #1;
         cyc++;
      end
      start_i = 0; dirty_valid_i = 0; rec_ready_i = 0;
      check(fin, {tag, " R10 done reached"}, fin, 1);
      @(negedge clk);
      check(!done_o, {tag, " R10 done single cycle"}, done_o, 0);
      check(n == ne, {tag, " R2 R3 R4 R7 record count"}, n, ne);
      for (int i = 0; i < ne && i < n && i < 80; i++) begin
         check(got_y[i] == exp_y[i], {tag, " R2 first line"}, got_y[i], exp_y[i]);
         check(got_n[i] == exp_n[i], {tag, " R3 R4 count"}, got_n[i], exp_n[i]);
      end
      check(w_ok, {tag, " R5 width"}, w_ok, 1);
      check(x_ok, {tag, " R5 column zero"}, x_ok, 1);
      check(stall_ok, {tag, " R8 scan stalls"}, stall_ok, 1);
      check(hold_ok, {tag, " R8 record held"}, hold_ok, 1);
      if (full) check(!scan_seen, {tag, " R6 no flag accepted"}, scan_seen, 0);
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd == 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", wd, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!rec_valid_o, "R1 valid low", rec_valid_o, 0);
      check(!done_o, "R1 done low", done_o, 0);
      check(!dirty_ready_o, "R1 flag ready low", dirty_ready_o, 0);
      rst_n = 1;
      for (int v = 0; v < 8; v++)
         run_frame(VEC[v].h, VEC[v].full, VEC[v].bits, VEC[v].rpat, VEC[v].w, -1,
                   $sformatf("vec%0d", v));
      // R9: a start mid-frame changes nothing
      run_frame(20, 1'b0, 64'h000F_0F00, 8'hC3, 500, 4, "r9_restart");
      // R9: a start just after done is honoured
      run_frame(30, 1'b1, 64'h0, 8'h99, 333, -1, "r9_after_done");
      // R7: empty frame of maximal bench height with stalling consumer
      run_frame(64, 1'b0, 64'h0, 8'h01, 50, -1, "r7_empty");
      // R4: stretch ending exactly on the last line
      run_frame(33, 1'b0, 64'h1_8000_0000, 8'h6D, 900, -1, "r4_tail");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule